// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block sits on the host side of a single-lane SPI link to a serial NOR flash. It drives the whole write sequence for one request: it unlocks the device for writing, sends the operation with its address and payload, then reads the device status over and over until the device reports that it is idle. A request names one of five operations (page program, 4 KB sector erase, 32 KB block erase, 64 KB block erase, whole-chip erase), a 24-bit byte address and, for a page program, a byte count. Program data is pulled from the host one byte at a time through a take strobe.

Every SPI transfer is its own chip-select frame, and chip select is held high for a set number of clock cycles between frames. Erase addresses are forced down to the start of the unit being erased. A program that would run past the end of its 256-byte page is refused before any SPI activity. The status polling has an upper limit, and the request ends with a timeout flag if the device stays busy past that limit.

Top module: `flash_prog_seq`

## Requirements
- R1: Every accepted request starts with a one-byte frame carrying 06h (write enable), followed by chip select going high before the operation frame starts.
- R2: The operation frame's first byte is selected by `req_op`: 0 page program sends 02h, 1 sector erase sends 20h, 2 32 KB erase sends 52h, 3 64 KB erase sends D8h, 4 chip erase sends C7h.
- R3: An erase of codes 1 to 3 sends three address bytes, most significant byte first, with the low 12, 15 or 16 address bits cleared. Chip erase sends the opcode alone.
- R4: A page program sends the address unchanged, then `req_len_m1`+1 data bytes in the order they were taken. `data_take` pulses exactly once for each byte, and the byte on `data_byte` in that cycle is the one sent.
- R5: A request whose op code is above 4, or a program where the low address byte plus `req_len_m1` exceeds 255, is refused. `done` and `err_range` pulse in the cycle after the request, and chip select stays high.
- R6: After the operation frame, the block sends repeated two-byte frames: 05h out and one status byte in. It stops at the first status byte whose bit 0 is 0, then pulses `done` with no error flag.
- R7: If `MAX_POLLS` status reads in a row all show bit 0 set, the block pulses `done` together with `err_timeout` and sends no further frame. A clear bit on the last permitted read counts as success.
- R8: SPI mode 0 is used. SCK is low whenever chip select is high, and MOSI does not change while SCK is high.
- R9: After reset, chip select is high, SCK is low, and `busy` and `done` are low. `busy` stays high from acceptance until `done`. Requests made while `busy` is high are ignored.
- R10: Chip select stays high for at least `CS_GAP` clock cycles between two frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code (0 program, 1 4K, 2 32K, 3 64K, 4 chip) |
| req_addr | input | 24 | Byte address |
| req_len_m1 | input | 8 | Program byte count minus one |
| data_byte | input | 8 | Next program byte |
| data_take | output | 1 | Program byte consumed this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | Request refused (with done) |
| err_timeout | output | 1 | Poll limit reached (with done) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two decisions can be due in the same cycle: completion, when a status byte shows bit 0 clear, and timeout, when the poll count reaches its limit. The bench's flash model is set to stay busy for exactly `MAX_POLLS`-1 reads, so the clear status arrives on the last permitted read. Success must win, with no timeout flag. A second run stays busy for `MAX_POLLS` reads and must end in timeout, after exactly `MAX_POLLS` status frames.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        OP_PAGE_PROG  = 3'd0,
        OP_ERASE_4K   = 3'd1,
        OP_ERASE_32K  = 3'd2,
        OP_ERASE_64K  = 3'd3,
        OP_ERASE_ALL  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PH_UNLOCK,
        PH_MAIN,
        PH_POLL
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP
    } state_e;

    typedef struct packed {
        op_e         op;
        logic [23:0] addr;
        logic [7:0]  len_m1;
    } req_t;

    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_STATUS = 8'h05;

    function automatic logic [7:0] op_code(op_e op);
        case (op)
            OP_PAGE_PROG: return 8'h02;
            OP_ERASE_4K:  return 8'h20;
            OP_ERASE_32K: return 8'h52;
            OP_ERASE_64K: return 8'hD8;
            default:      return 8'hC7;
        endcase
    endfunction

    function automatic logic [23:0] align_addr(op_e op, logic [23:0] a);
        case (op)
            OP_ERASE_4K:  return {a[23:12], 12'h000};
            OP_ERASE_32K: return {a[23:15], 15'h0000};
            OP_ERASE_64K: return {a[23:16], 16'h0000};
            default:      return a;
        endcase
    endfunction

    function automatic logic req_ok(logic [2:0] op, logic [7:0] lo, logic [7:0] len_m1);
        if (op > 3'd4) return 1'b0;
        if (op == 3'd0) return ({1'b0, lo} + {1'b0, len_m1}) <= 9'd255;
        return 1'b1;
    endfunction

    // index of the final byte in a frame
    function automatic logic [8:0] frame_last(phase_e ph, op_e op, logic [7:0] len_m1);
        case (ph)
            PH_UNLOCK: return 9'd0;
            PH_POLL:   return 9'd1;
            default: begin
                if (op == OP_ERASE_ALL) return 9'd0;
                if (op == OP_PAGE_PROG) return 9'd4 + {1'b0, len_m1};
                return 9'd3;
            end
        endcase
    endfunction

endpackage

// File: rtl/fseq_spi_byte.sv
module fseq_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_END = DW'(CLK_DIV - 1);

    logic [DW-1:0] divc;
    logic [2:0]    bitc;
    logic [7:0]    sh;
    logic          run;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            divc <= '0;
            bitc <= '0;
            sh   <= '0;
            run  <= 1'b0;
            sck  <= 1'b0;
            done <= 1'b0;
            rx   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run  <= 1'b1;
                sh   <= tx;
                divc <= '0;
                bitc <= '0;
                sck  <= 1'b0;
            end else if (run) begin
                if (divc == DIV_END) begin
                    divc <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitc == 3'd7) begin
                            run  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitc <= bitc + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    divc <= divc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fseq_poll_limit.sv
module fseq_poll_limit #(
    parameter int MAX_POLLS = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LAST);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fseq_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int CS_GAP    = 4,
    parameter int MAX_POLLS = 65536
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [23:0] req_addr,
    input  logic [7:0]  req_len_m1,
    input  logic [7:0]  data_byte,
    output logic        data_take,
    output logic        busy,
    output logic        done,
    output logic        err_range,
    output logic        err_timeout,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [GW-1:0] GAP_END = GW'(CS_GAP - 1);

    state_e      state;
    phase_e      phase;
    req_t        rq;
    logic [8:0]  idx;
    logic [GW-1:0] gap_cnt;
    logic [7:0]  last_rx;
    logic [7:0]  cur_byte;
    logic [23:0] tx_addr;
    logic        sh_done;
    logic [7:0]  sh_rx;
    logic        gap_end;
    logic        at_limit;
    logic        poll_inc;

    assign busy     = (state != ST_IDLE);
    assign spi_cs_n = !(state == ST_LOAD || state == ST_SHIFT);
    assign gap_end  = (state == ST_GAP) && (gap_cnt == GAP_END);
    assign poll_inc = gap_end && (phase == PH_POLL) && last_rx[0];
    assign tx_addr  = align_addr(rq.op, rq.addr);

    assign data_take = (state == ST_LOAD) && (phase == PH_MAIN) &&
                       (rq.op == OP_PAGE_PROG) && (idx >= 9'd4);

    always_comb begin
        cur_byte = 8'h00;
        case (phase)
            PH_UNLOCK: cur_byte = CMD_WREN;
            PH_POLL:   cur_byte = (idx == 9'd0) ? CMD_STATUS : 8'h00;
            default: begin
                case (idx)
                    9'd0:    cur_byte = op_code(rq.op);
                    9'd1:    cur_byte = tx_addr[23:16];
                    9'd2:    cur_byte = tx_addr[15:8];
                    9'd3:    cur_byte = tx_addr[7:0];
                    default: cur_byte = data_byte;
                endcase
            end
        endcase
    end

    fseq_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (state == ST_LOAD),
        .tx    (cur_byte),
        .miso  (spi_miso),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    fseq_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk      (clk),
        .rst      (rst),
        .clr      (state == ST_IDLE),
        .inc      (poll_inc),
        .at_limit (at_limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            phase       <= PH_UNLOCK;
            rq          <= '0;
            idx         <= '0;
            gap_cnt     <= '0;
            last_rx     <= '0;
            done        <= 1'b0;
            err_range   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            done        <= 1'b0;
            err_range   <= 1'b0;
            err_timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!req_ok(req_op, req_addr[7:0], req_len_m1)) begin
                            done      <= 1'b1;
                            err_range <= 1'b1;
                        end else begin
                            rq.op     <= op_e'(req_op);
                            rq.addr   <= req_addr;
                            rq.len_m1 <= req_len_m1;
                            phase     <= PH_UNLOCK;
                            idx       <= '0;
                            state     <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (idx == frame_last(phase, rq.op, rq.len_m1)) begin
                            state   <= ST_GAP;
                            gap_cnt <= '0;
                            last_rx <= sh_rx;
                        end else begin
                            idx   <= idx + 9'd1;
                            state <= ST_LOAD;
                        end
                    end
                end
                default: begin
                    if (gap_end) begin
                        idx <= '0;
                        case (phase)
                            PH_UNLOCK: begin
                                phase <= PH_MAIN;
                                state <= ST_LOAD;
                            end
                            PH_MAIN: begin
                                phase <= PH_POLL;
                                state <= ST_LOAD;
                            end
                            default: begin
                                if (!last_rx[0]) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else if (at_limit) begin
                                    done        <= 1'b1;
                                    err_timeout <= 1'b1;
                                    state       <= ST_IDLE;
                                end else begin
                                    state <= ST_LOAD;
                                end
                            end
                        endcase
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
    parameter int CS_GAP = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic err_range,
    input logic err_timeout,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    localparam int HW = $clog2(CS_GAP + 2);
    localparam logic [HW-1:0] HMAX = HW'(CS_GAP);

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)               hi_run <= HMAX;
        else if (!spi_cs_n)    hi_run <= '0;
        else if (hi_run < HMAX) hi_run <= hi_run + 1'b1;
    end

    // R8
    a_r8_sck_low_idle: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);
    // R8
    a_r8_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
    // R10
    a_r10_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_run >= HMAX));
    // R5
    a_r5_reject_idle: assert property (@(posedge clk) disable iff (rst)
        err_range |-> (done && !busy && spi_cs_n));
    // R7
    a_r7_timeout_done: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> (done && !err_range));
    // R9
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        (done && !err_range) |-> ($past(busy) && !busy));
    // R9
    a_r9_idle_deselect: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);
endmodule

bind flash_prog_seq fseq_checker #(.CS_GAP(CS_GAP)) u_fseq_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .err_range   (err_range),
    .err_timeout (err_timeout),
    .spi_cs_n    (spi_cs_n),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi)
);

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
    localparam int CLK_DIV = 2;
    localparam int CS_GAP  = 3;
    localparam int MAXP    = 5;

    typedef struct packed {
        logic [2:0]  op;
        logic [23:0] addr;
        logic [7:0]  lm1;
        logic [7:0]  bp;
        logic [23:0] xaddr;
        logic [1:0]  xerr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 24'h123456, 8'd0,   8'd2, 24'h123000, 2'd0},
        '{3'd2, 24'h12FFFF, 8'd0,   8'd0, 24'h128000, 2'd0},
        '{3'd3, 24'h3ABCDE, 8'd0,   8'd1, 24'h3A0000, 2'd0},
        '{3'd4, 24'h055555, 8'd0,   8'd3, 24'h000000, 2'd0},
        '{3'd0, 24'h001200, 8'd255, 8'd1, 24'h001200, 2'd0},
        '{3'd0, 24'h0004F0, 8'd15,  8'd0, 24'h0004F0, 2'd0},
        '{3'd0, 24'h0004F0, 8'd16,  8'd0, 24'h000000, 2'd1},
        '{3'd6, 24'h000000, 8'd0,   8'd0, 24'h000000, 2'd1},
        '{3'd1, 24'h000FFF, 8'd0,   8'd4, 24'h000000, 2'd0},
        '{3'd1, 24'h001001, 8'd0,   8'd5, 24'h001000, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [23:0] req_addr;
    logic [7:0]  req_len_m1;
    logic [7:0]  data_byte;
    logic        data_take, busy, done, err_range, err_timeout;
    logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_prog_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .data_byte(data_byte),
        .data_take(data_take), .busy(busy), .done(done), .err_range(err_range),
        .err_timeout(err_timeout), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_opc(logic [2:0] op);
        case (op)
            3'd0: return 8'h02;
            3'd1: return 8'h20;
            3'd2: return 8'h52;
            3'd3: return 8'hD8;
            default: return 8'hC7;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // program data source
    int take_cnt;
    logic take_clr = 1'b0;
    always @(posedge clk) begin
        if (take_clr) take_cnt <= 0;
        else if (data_take) take_cnt <= take_cnt + 1;
    end
    assign data_byte = pat(take_cnt);

    // flash model
    logic [7:0] sh_in, stat_sh;
    logic [7:0] fb [0:3];
    int bitn, fcnt, wip_left, bp_cfg, data_bad, nframes;
    int         log_n  [0:39];
    logic [7:0] log_b0 [0:39];
    logic [7:0] log_b1 [0:39];
    logic [7:0] log_b2 [0:39];
    logic [7:0] log_b3 [0:39];

    initial begin
        stat_sh = 8'h00; bitn = 0; fcnt = 0; wip_left = 0; bp_cfg = 0;
        data_bad = 0; nframes = 0;
        for (int i = 0; i < 4; i++) fb[i] = 8'h00;
    end

    assign spi_miso = stat_sh[7];

    always @(negedge spi_cs_n) begin
        bitn = 0;
        fcnt = 0;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        sh_in   = {sh_in[6:0], spi_mosi};
        stat_sh = {stat_sh[6:0], 1'b0};
        bitn++;
        if (bitn == 8) begin
            bitn = 0;
            if (fcnt < 4) fb[fcnt] = sh_in;
            if (fcnt == 0 && sh_in == 8'h05) stat_sh = {7'b0, wip_left != 0};
            if (fcnt >= 4 && fb[0] == 8'h02 && sh_in != pat(fcnt - 4)) data_bad++;
            fcnt++;
        end
    end

    always @(posedge spi_cs_n) if (rst === 1'b0) begin
        if (nframes < 40) begin
            log_n[nframes]  = fcnt;
            log_b0[nframes] = fb[0];
            log_b1[nframes] = fb[1];
            log_b2[nframes] = fb[2];
            log_b3[nframes] = fb[3];
        end
        nframes++;
        if (fb[0] == 8'h05) begin
            if (wip_left > 0) wip_left--;
        end else if (fb[0] != 8'h06) begin
            wip_left = bp_cfg;
        end
    end

    // bus monitors (R8, R10)
    int r8_viol = 0;
    int hi_len = 0;
    int min_gap = 1000;
    int done_cnt = 0;
    logic prev_sck = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
    logic seen_frame = 1'b0;
    always @(negedge clk) if (rst === 1'b0) begin
        if (spi_cs_n && spi_sck) r8_viol++;
        if (spi_sck && prev_sck && spi_mosi != prev_mosi) r8_viol++;
        if (prev_cs && !spi_cs_n) begin
            if (seen_frame && hi_len < min_gap) min_gap = hi_len;
            seen_frame = 1'b1;
        end
        hi_len = spi_cs_n ? hi_len + 1 : 0;
        if (done) done_cnt++;
        prev_sck = spi_sck; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
    end

    logic g_done, g_rng, g_to;

    task automatic launch(input logic [2:0] op, input logic [23:0] a, input logic [7:0] l, input int bp);
        @(negedge clk);
        bp_cfg = bp; nframes = 0; data_bad = 0; wip_left = 0;
        take_clr = 1'b1;
        @(negedge clk);
        take_clr = 1'b0;
        req_op = op; req_addr = a; req_len_m1 = l; req_valid = 1'b1;
    endtask

    task automatic wait_done();
        g_done = 1'b0; g_rng = 1'b0; g_to = 1'b0;
        for (int c = 0; c < 40000; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done) begin
                g_done = 1'b1; g_rng = err_range; g_to = err_timeout;
                break;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len_m1 = '0;
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R9 reset bus", {spi_cs_n, spi_sck}, 2'b10);
        chk(busy === 1'b0 && done === 1'b0, "R9 reset status", {busy, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            int xf, xn;
            t = VECS[v];
            launch(t.op, t.addr, t.lm1, int'(t.bp));
            wait_done();
            repeat (4) @(negedge clk);
            xf = (t.xerr == 2'd1) ? 0 : (t.xerr == 2'd2) ? 2 + MAXP : 3 + int'(t.bp);
            xn = (t.op == 3'd4) ? 1 : (t.op == 3'd0) ? 5 + int'(t.lm1) : 4;
            chk(g_done, "R6 done seen", g_done, 1);
            chk(g_rng == (t.xerr == 2'd1), "R5 err_range", g_rng, t.xerr == 2'd1);
            chk(g_to == (t.xerr == 2'd2), "R7 err_timeout", g_to, t.xerr == 2'd2);
            chk(nframes == xf, "R6 R7 frame count", nframes, xf);
            if (xf > 0 && nframes == xf) begin
                chk(log_b0[0] == 8'h06 && log_n[0] == 1, "R1 write enable frame", {log_b0[0], 8'(log_n[0])}, 16'h0601);
                chk(log_b0[1] == exp_opc(t.op), "R2 opcode", log_b0[1], exp_opc(t.op));
                chk(log_n[1] == xn, "R3 R4 frame length", log_n[1], xn);
                if (t.op != 3'd4)
                    chk({log_b1[1], log_b2[1], log_b3[1]} == t.xaddr, "R3 R4 address",
                        {log_b1[1], log_b2[1], log_b3[1]}, t.xaddr);
                for (int f = 2; f < xf; f++)
                    chk(log_b0[f] == 8'h05 && log_n[f] == 2, "R6 status frame", {log_b0[f], 8'(log_n[f])}, 16'h0502);
                if (t.op == 3'd0) begin
                    chk(take_cnt == int'(t.lm1) + 1, "R4 take count", take_cnt, int'(t.lm1) + 1);
                    chk(data_bad == 0, "R4 data order", data_bad, 0);
                end
            end
            if (t.xerr == 2'd1)
                chk(take_cnt == 0, "R5 no data taken", take_cnt, 0);
        end

        // R9: request while busy is ignored
        begin
            int d0;
            d0 = done_cnt;
            launch(3'd4, 24'h0, 8'd0, 2);
            repeat (30) @(negedge clk);
            req_valid = 1'b0;
            chk(busy === 1'b1, "R9 busy during op", busy, 1);
            req_op = 3'd1; req_addr = 24'h777777; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            wait_done();
            repeat (300) @(negedge clk);
            chk(nframes == 5, "R9 ignored request frames", nframes, 5);
            chk(log_b0[1] == 8'hC7, "R9 first request kept", log_b0[1], 8'hC7);
            chk(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);
            chk(busy === 1'b0 && spi_cs_n === 1'b1, "R9 idle after", {busy, spi_cs_n}, 2'b01);
        end

        chk(r8_viol == 0, "R8 mode 0 bus", r8_viol, 0);
        chk(min_gap >= CS_GAP, "R10 chip select gap", min_gap, CS_GAP);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule